// File: doc/BRIEF.md
# Dual Edge-Qualified Binary Counter

This block holds two independent 4-bit binary up-counters. Each counter owns a pair of count inputs of opposite polarity: one advances the count on its rising edge, the other on its falling edge. The level of each input acts as an enable for the other. A rising-edge input counts only while the falling-edge input is high. A falling-edge input counts only while the rising-edge input is low. Either input can therefore be used as the count clock and the other as a count enable.

All logic runs on one fast system clock. Every count input passes through a two-stage synchroniser. Edges are found by comparing each new synchronised sample with the one before it. Each counter also has its own active-high clear. The clear zeroes the count at once, holds it at zero while it stays high, and is released in step with the system clock. A carry flag per counter marks the terminal count.

Top module: `dual_edge_counter`

## Requirements
- R1: The two counters are independent, and each is 4 bits wide in straight binary. Counter i appears on `count_o[4*i+3:4*i]` and is driven only by `rise_in[i]`, `fall_in[i]` and `clear_in[i]`. A qualifying edge is reflected in the count within three system-clock cycles.
- R2: A low-to-high change on `rise_in[i]` while `fall_in[i]` is high adds one to counter i.
- R3: A high-to-low change on `fall_in[i]` while `rise_in[i]` is low adds one to counter i.
- R4: A high-to-low change on `rise_in[i]` or a low-to-high change on `fall_in[i]` leaves counter i unchanged.
- R5: A rising `rise_in[i]` while `fall_in[i]` is low does not count. A falling `fall_in[i]` while `rise_in[i]` is high does not count either.
- R6: While `clear_in[i]` is high, counter i reads zero without waiting for a clock edge, and edges on its inputs are ignored. After release, counting resumes from zero.
- R7: The count wraps from 15 to 0 on the next qualifying edge. `carry_o[i]` is high exactly while counter i equals 15.
- R8: When both inputs of a counter change in the same sample, the counter advances at most once, and the enable is judged on the new levels. Both rising counts once, both falling counts once, and the two opposite mixes do not count.
- R9: A high `rst` zeroes both counters at the next clock edge. Input levels already present when `rst` is released produce no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all count inputs |
| rst | input | 1 | Synchronous active-high system reset |
| rise_in | input | 2 | Rising-edge count input, one per counter |
| fall_in | input | 2 | Falling-edge count input, one per counter |
| clear_in | input | 2 | Active-high clear, one per counter |
| count_o | output | 8 | Count values, counter i in bits 4*i+3..4*i |
| carry_o | output | 2 | High while the matching counter is at 15 |

## Verification
The main function is driven through a walk of level changes that covers every single-input transition under both enable levels. This separates the two counting edges from the two non-counting edges and from edges that the enable blocks. Simultaneous changes of both inputs in all four combinations show whether the enable is judged on the new levels and whether a double change counts once. Activity on one counter while the other sits idle checks that the two counters are independent. Directed runs then cover the wrap at 15 with the carry flag, a clear that arrives between clock edges with edges inside it, and a system reset released while an enabling level is already present.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic rise_lvl;
        logic fall_lvl;
    } pin_pair_t;

    // One count step: rising-edge input goes up with the other input high,
    // or falling-edge input goes down with the other input low.
    // Enables are judged on the new sample.
    function automatic logic qualify(input pin_pair_t now_s, input pin_pair_t prev_s);
        logic up_ok;
        logic dn_ok;
        up_ok = now_s.rise_lvl & ~prev_s.rise_lvl & now_s.fall_lvl;
        dn_ok = ~now_s.fall_lvl & prev_s.fall_lvl & ~now_s.rise_lvl;
        return up_ok | dn_ok;
    endfunction

endpackage

// File: rtl/edge_qual.sv
module edge_qual
    import dec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_in,
    input  logic fall_in,
    output logic step
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0]         rise_sh;
    logic [TOP:0]         fall_sh;
    logic [SYNC_STAGES:0] warm;
    pin_pair_t            now_s;
    pin_pair_t            prev_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_sh <= '0;
            fall_sh <= '0;
            warm    <= '0;
            prev_s  <= '0;
        end else begin
            rise_sh <= {rise_sh[TOP-1:0], rise_in};
            fall_sh <= {fall_sh[TOP-1:0], fall_in};
            warm    <= {warm[SYNC_STAGES-1:0], 1'b1};
            prev_s  <= now_s;
        end
    end

    always_comb begin
        now_s.rise_lvl = rise_sh[TOP];
        now_s.fall_lvl = fall_sh[TOP];
    end

    // No step until the synchroniser has filled after reset
    assign step = warm[SYNC_STAGES] & qualify(now_s, prev_s);

    assert_no_count_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        ((now_s.rise_lvl && !prev_s.rise_lvl && !now_s.fall_lvl && !(prev_s.fall_lvl && !now_s.rise_lvl))
         || (!now_s.fall_lvl && prev_s.fall_lvl && now_s.rise_lvl)) |-> !step);

    assert_opposite_mix_R8: assert property (@(posedge clk) disable iff (rst)
        ((now_s.rise_lvl != prev_s.rise_lvl) && (now_s.fall_lvl != prev_s.fall_lvl)
         && (now_s.rise_lvl != now_s.fall_lvl)) |-> !step);

    assert_fall_counts_R3: assert property (@(posedge clk) disable iff (rst)
        (warm[SYNC_STAGES] && prev_s.fall_lvl && !now_s.fall_lvl && !now_s.rise_lvl) |-> step);

endmodule

// File: rtl/clr_sync.sv
module clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_in,
    output logic clr_hold
);
    logic [STAGES-1:0] sh;

    // Asserts at once, releases after STAGES clock edges
    always_ff @(posedge clk or posedge clr_in) begin
        if (clr_in)
            sh <= '1;
        else if (rst)
            sh <= '0;
        else
            sh <= {sh[STAGES-2:0], 1'b0};
    end

    assign clr_hold = sh[STAGES-1];
endmodule

// File: rtl/nib_counter.sv
module nib_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_hold,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         carry
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge clr_hold) begin
        if (clr_hold)
            cnt_q <= '0;
        else if (rst)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign carry = &cnt_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !clr_hold) |=> (clr_hold || count == W'($past(count) + 1'b1)));

    assert_hold_no_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!step) |=> (clr_hold || $stable(count)));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr_hold |-> (count == '0));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !clr_hold && carry) |=> (count == '0 && !carry));
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter
    import dec_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = NIB_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       rise_in,
    input  logic [NUM_CH-1:0]       fall_in,
    input  logic [NUM_CH-1:0]       clear_in,
    output logic [NUM_CH*CNT_W-1:0] count_o,
    output logic [NUM_CH-1:0]       carry_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic step;
        logic clr_hold;

        edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst     (rst),
            .rise_in (rise_in[ch]),
            .fall_in (fall_in[ch]),
            .step    (step)
        );

        clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
            .clk      (clk),
            .rst      (rst),
            .clr_in   (clear_in[ch]),
            .clr_hold (clr_hold)
        );

        nib_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr_hold (clr_hold),
            .step     (step),
            .count    (count_o[ch*CNT_W +: CNT_W]),
            .carry    (carry_o[ch])
        );
    end
endmodule

// File: tb/dual_edge_counter_test.sv
module dual_edge_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;
    // [15:12] requirement number, [11:8] expected count 0, [7:4] expected count 1,
    // [3:0] levels {rise0, fall0, rise1, fall1}
    localparam logic [15:0] VEC [NV] = '{
        16'h4004, 16'h210C, 16'h4104, 16'h220C, 16'h5208, 16'h4200, 16'h5208,
        16'h4200, 16'h4204, 16'h3300, 16'h4304, 16'h3400, 16'h850C, 16'h8600,
        16'h4604, 16'h8608, 16'h8604, 16'h1605, 16'h1617, 16'h1615, 16'h3624
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rise_in = '0;
    logic [1:0] fall_in = '0;
    logic [1:0] clear_in = '0;
    logic [7:0] count_o;
    logic [1:0] carry_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    dual_edge_counter uut (
        .clk(clk), .rst(rst), .rise_in(rise_in), .fall_in(fall_in),
        .clear_in(clear_in), .count_o(count_o), .carry_o(carry_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pins(input logic r0, input logic f0, input logic r1, input logic f1);
        @(negedge clk);
        rise_in = {r1, r0};
        fall_in = {f1, f0};
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R9 reset count0", int'(count_o[3:0]), 0);
        chk("R9 reset count1", int'(count_o[7:4]), 0);
        chk("R7 reset carry", int'(carry_o), 0);

        for (int i = 0; i < NV; i++) begin
            pins(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
            chk($sformatf("R%0d vec%0d count0", VEC[i][15:12], i), int'(count_o[3:0]), int'(VEC[i][11:8]));
            chk($sformatf("R%0d vec%0d count1", VEC[i][15:12], i), int'(count_o[7:4]), int'(VEC[i][7:4]));
        end

        // R7: wrap of counter 1 via falling-edge pulses (rise1 low), from 2
        for (int k = 0; k < 12; k++) begin
            pins(1'b0, 1'b1, 1'b0, 1'b1);
            pins(1'b0, 1'b1, 1'b0, 1'b0);
        end
        chk("R7 count1 at 14", int'(count_o[7:4]), 14);
        chk("R7 carry low at 14", int'(carry_o[1]), 0);
        pins(1'b0, 1'b1, 1'b0, 1'b1);
        pins(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 count1 at 15", int'(count_o[7:4]), 15);
        chk("R7 carry high at 15", int'(carry_o[1]), 1);
        pins(1'b0, 1'b1, 1'b0, 1'b1);
        pins(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 count1 wrapped", int'(count_o[7:4]), 0);
        chk("R7 carry low after wrap", int'(carry_o[1]), 0);

        // R6: clear of counter 0 (at 6) between clock edges
        @(negedge clk);
        clear_in[0] = 1'b1;
        #1;
        chk("R6 immediate clear", int'(count_o[3:0]), 0);
        pins(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6 edge ignored in clear", int'(count_o[3:0]), 0);
        chk("R1 other counter untouched", int'(count_o[7:4]), 0);
        @(negedge clk);
        clear_in[0] = 1'b0;
        settle();
        chk("R6 zero after release", int'(count_o[3:0]), 0);
        pins(1'b0, 1'b1, 1'b0, 1'b0);
        pins(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6 counts after release", int'(count_o[3:0]), 1);

        // R9: system reset released with an enabling level present
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset zeroes count0", int'(count_o[3:0]), 0);
        rst = 1'b0;
        settle();
        settle();
        chk("R9 no count on release", int'(count_o[3:0]), 0);
        pins(1'b0, 1'b1, 1'b0, 1'b0);
        pins(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R9 counts after reset", int'(count_o[3:0]), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule